// File: doc/BRIEF.md
# Memory Address Generation Unit

This block produces the physical address that a processor core places on its address register. It keeps three pointers: a program counter for instruction fetch, a stack pointer for push and pop, and an index register for array access. A single adder combines one of those pointers with an increment, a decrement or a signed byte offset taken from the internal data bus. Memory is one linear 16-bit space, and every sum wraps modulo 2^16.

Each operation is started by a one-cycle `go` strobe together with a 3-bit mode code. All results are registered, so the new address and the new pointer values appear one clock after the strobe. A full absolute address reaches the block over the 8-bit bus in two separate transfers. Each transfer lands in one byte lane of a holding register, selected by its own strobe. The absolute jump and absolute data modes read that holding register, and a separate strobe copies it into the index register.

Top module: `addr_gen_unit`

## Requirements
- R1: After reset the address output is 0000h, the program counter 0100h, the stack pointer FFFFh and the index register 0000h.
- R2: Mode 0 (fetch) copies the program counter to the address output and then advances the program counter by one, wrapping from FFFFh to 0000h.
- R3: Mode 1 (absolute jump) loads both the address output and the program counter with the holding register.
- R4: Mode 2 (relative jump) sign-extends the bus byte, adds it to the program counter modulo 2^16, and writes the sum to both the program counter and the address output.
- R5: Mode 3 (absolute data) loads the address output with the holding register and leaves the program counter unchanged.
- R6: Mode 4 (relative data) puts the program counter plus the sign-extended bus byte on the address output and leaves the program counter unchanged.
- R7: Mode 5 (push) decrements the stack pointer, wrapping from 0000h to FFFFh, and places the decremented value on the address output.
- R8: Mode 6 (pop) places the current stack pointer on the address output and then increments the stack pointer, wrapping from FFFFh to 0000h.
- R9: Mode 7 (indexed) puts the index register plus the sign-extended bus byte on the address output and leaves the index register unchanged.
- R10: `byte_ld[0]` captures the bus byte as bits 7:0 of the holding register, and `byte_ld[1]` captures it as bits 15:8. Each lane keeps its value until its own strobe is given again. `ix_load` copies the holding register into the index register.
- R11: While `go` is low, the address output, program counter and stack pointer keep their values whatever the mode and bus inputs do.
- R12: A mode changes only the pointers named in its own requirement. Jumps and data modes leave the stack pointer alone, stack modes leave the program counter alone, and no mode changes the index register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Starts the operation selected by `mode` |
| mode | input | 3 | Operation code, values 0 to 7 as listed in R2 to R9 |
| bus_in | input | 8 | Internal data bus: offset byte or address byte |
| byte_ld | input | 2 | Byte-lane strobes for the holding register (bit 0 low byte, bit 1 high byte) |
| ix_load | input | 1 | Copies the holding register into the index register |
| addr_q | output | 16 | Address register |
| pc_q | output | 16 | Program counter |
| sp_q | output | 16 | Stack pointer |
| ix_q | output | 16 | Index register |

## Verification
The bench sweeps all 256 offset bytes through the relative jump, relative data and indexed modes. The bases are chosen so that many sums cross the top or the bottom of the address space. An adder that zero-extends the offset, or that keeps a 17th bit, shows up as a wrong address for every negative offset or for every wrapped sum. The stack pointer is driven across its wrap in both directions and pushed and popped in LIFO order. An off-by-one choice between pre-decrement and post-decrement therefore shows up as a shifted address. The bench also checks that relative data leaves the program counter alone, that the two address bytes are not swapped, and that idle cycles with a changing mode and bus move no pointer.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    M_FETCH = 3'd0,
    M_JABS  = 3'd1,
    M_JREL  = 3'd2,
    M_DABS  = 3'd3,
    M_DREL  = 3'd4,
    M_PUSH  = 3'd5,
    M_POP   = 3'd6,
    M_INDEX = 3'd7
  } agu_mode_e;

  typedef enum logic [1:0] {
    BASE_PC = 2'd0,
    BASE_SP = 2'd1,
    BASE_IX = 2'd2
  } base_sel_e;

  typedef enum logic [1:0] {
    STEP_OFS = 2'd0,
    STEP_INC = 2'd1,
    STEP_DEC = 2'd2
  } step_sel_e;

  typedef enum logic [1:0] {
    AR_SUM = 2'd0,
    AR_TMP = 2'd1,
    AR_PC  = 2'd2,
    AR_SP  = 2'd3
  } ar_src_e;

  typedef enum logic [1:0] {
    PC_KEEP = 2'd0,
    PC_SUM  = 2'd1,
    PC_TMP  = 2'd2
  } pc_src_e;

  typedef struct packed {
    base_sel_e base;
    step_sel_e step;
    ar_src_e   ar_src;
    pc_src_e   pc_src;
    logic      sp_wr;
  } agu_ctl_t;

  // One row per mode: which pointer feeds the adder, what is added, where results go.
  function automatic agu_ctl_t decode_mode(agu_mode_e m);
    agu_ctl_t c;
    c.base   = BASE_PC;
    c.step   = STEP_OFS;
    c.ar_src = AR_SUM;
    c.pc_src = PC_KEEP;
    c.sp_wr  = 1'b0;
    case (m)
      M_FETCH: begin c.step = STEP_INC; c.ar_src = AR_PC; c.pc_src = PC_SUM; end
      M_JABS:  begin c.ar_src = AR_TMP; c.pc_src = PC_TMP; end
      M_JREL:  begin c.pc_src = PC_SUM; end
      M_DABS:  begin c.ar_src = AR_TMP; end
      M_DREL:  begin c.ar_src = AR_SUM; end
      M_PUSH:  begin c.base = BASE_SP; c.step = STEP_DEC; c.sp_wr = 1'b1; end
      M_POP:   begin c.base = BASE_SP; c.step = STEP_INC; c.ar_src = AR_SP; c.sp_wr = 1'b1; end
      M_INDEX: begin c.base = BASE_IX; end
      default: begin end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/agu_addr_temp.sv
module agu_addr_temp #(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int NB = AW / DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] lane_ld,
  input  logic [DW-1:0] din,
  output logic [AW-1:0] tmp
);

  // One register per byte lane; lane 0 is the least significant byte.
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [DW-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n)          lane_q <= '0;
      else if (lane_ld[g]) lane_q <= din;
    end
    assign tmp[g*DW +: DW] = lane_q;
  end

endmodule

// File: rtl/agu_sum_path.sv
module agu_sum_path
  import agu_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  base_sel_e     base_sel,
  input  step_sel_e     step_sel,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] sp,
  input  logic [AW-1:0] ix,
  input  logic [DW-1:0] ofs,
  output logic [AW-1:0] base_w,
  output logic [AW-1:0] step_w,
  output logic [AW-1:0] sum
);

  function automatic logic [AW-1:0] sext_ofs(logic [DW-1:0] b);
    return {{(AW-DW){b[DW-1]}}, b};
  endfunction

  function automatic logic [AW-1:0] wrap_add(logic [AW-1:0] a, logic [AW-1:0] b);
    logic [AW:0] full;
    full = {1'b0, a} + {1'b0, b};
    return full[AW-1:0];
  endfunction

  always_comb begin
    case (base_sel)
      BASE_SP: base_w = sp;
      BASE_IX: base_w = ix;
      default: base_w = pc;
    endcase
  end

  always_comb begin
    case (step_sel)
      STEP_INC: step_w = {{(AW-1){1'b0}}, 1'b1};
      STEP_DEC: step_w = '1;
      default:  step_w = sext_ofs(ofs);
    endcase
  end

  assign sum = wrap_add(base_w, step_w);

endmodule

// File: rtl/agu_ptr_file.sv
module agu_ptr_file
  import agu_pkg::*;
#(
  parameter int          AW     = 16,
  parameter logic [15:0] PC_RST = 16'h0100,
  parameter logic [15:0] SP_RST = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  agu_ctl_t      ctl,
  input  logic [AW-1:0] sum,
  input  logic [AW-1:0] tmp,
  input  logic          ix_load,
  output logic [AW-1:0] ar_q,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] sp_q,
  output logic [AW-1:0] ix_q
);

  logic [AW-1:0] ar_nxt;
  logic [AW-1:0] pc_nxt;

  always_comb begin
    case (ctl.ar_src)
      AR_TMP:  ar_nxt = tmp;
      AR_PC:   ar_nxt = pc_q;
      AR_SP:   ar_nxt = sp_q;
      default: ar_nxt = sum;
    endcase
  end

  always_comb begin
    case (ctl.pc_src)
      PC_SUM:  pc_nxt = sum;
      PC_TMP:  pc_nxt = tmp;
      default: pc_nxt = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ar_q <= '0;
      pc_q <= AW'(PC_RST);
      sp_q <= AW'(SP_RST);
    end else if (go) begin
      ar_q <= ar_nxt;
      pc_q <= pc_nxt;
      if (ctl.sp_wr) sp_q <= sum;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ix_q <= '0;
    else if (ix_load) ix_q <= tmp;
  end

endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
  import agu_pkg::*;
#(
  parameter int          AW     = 16,
  parameter int          DW     = 8,
  parameter logic [15:0] PC_RST = 16'h0100,
  parameter logic [15:0] SP_RST = 16'hFFFF,
  localparam int         NB     = AW / DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [2:0]    mode,
  input  logic [DW-1:0] bus_in,
  input  logic [NB-1:0] byte_ld,
  input  logic          ix_load,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] sp_q,
  output logic [AW-1:0] ix_q
);

  agu_ctl_t      ctl_w;
  logic [AW-1:0] tmp_w;
  logic [AW-1:0] base_w;
  logic [AW-1:0] step_w;
  logic [AW-1:0] sum_w;

  assign ctl_w = decode_mode(agu_mode_e'(mode));

  agu_addr_temp #(.AW(AW), .DW(DW)) i_temp (
    .clk     (clk),
    .rst_n   (rst_n),
    .lane_ld (byte_ld),
    .din     (bus_in),
    .tmp     (tmp_w)
  );

  agu_sum_path #(.AW(AW), .DW(DW)) i_sum (
    .base_sel (ctl_w.base),
    .step_sel (ctl_w.step),
    .pc       (pc_q),
    .sp       (sp_q),
    .ix       (ix_q),
    .ofs      (bus_in),
    .base_w   (base_w),
    .step_w   (step_w),
    .sum      (sum_w)
  );

  agu_ptr_file #(.AW(AW), .PC_RST(PC_RST), .SP_RST(SP_RST)) i_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .ctl     (ctl_w),
    .sum     (sum_w),
    .tmp     (tmp_w),
    .ix_load (ix_load),
    .ar_q    (addr_q),
    .pc_q    (pc_q),
    .sp_q    (sp_q),
    .ix_q    (ix_q)
  );

endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic [2:0]    mode,
  input logic [DW-1:0] bus_in,
  input logic          ix_load,
  input logic [AW-1:0] addr_q,
  input logic [AW-1:0] pc_q,
  input logic [AW-1:0] sp_q,
  input logic [AW-1:0] ix_q
);

  logic [AW-1:0] ofs_x;
  assign ofs_x = {{(AW-DW){bus_in[DW-1]}}, bus_in};

  logic [AW-1:0] one_w;
  assign one_w = {{(AW-1){1'b0}}, 1'b1};

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> ($stable(addr_q) && $stable(pc_q) && $stable(sp_q)));

  p_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && mode == 3'd0) |=> (addr_q == $past(pc_q) && pc_q == $past(pc_q) + one_w));

  p_abs_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (go && mode == 3'd1) |=> (pc_q == addr_q && $stable(sp_q)));

  p_rel_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && mode == 3'd2) |=> (pc_q == $past(pc_q) + $past(ofs_x) && addr_q == pc_q));

  p_data_keeps_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (mode == 3'd3 || mode == 3'd4)) |=> ($stable(pc_q) && $stable(sp_q)));

  p_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && mode == 3'd5) |=> (sp_q == $past(sp_q) - one_w && addr_q == sp_q && $stable(pc_q)));

  p_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (go && mode == 3'd6) |=> (addr_q == $past(sp_q) && sp_q == $past(sp_q) + one_w));

  p_indexed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (go && mode == 3'd7 && !ix_load) |=> (addr_q == $past(ix_q) + $past(ofs_x) && $stable(ix_q)));

  p_ix_untouched_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ix_load |=> $stable(ix_q));

endmodule

bind addr_gen_unit agu_checker #(.AW(AW), .DW(DW)) i_agu_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .go      (go),
  .mode    (mode),
  .bus_in  (bus_in),
  .ix_load (ix_load),
  .addr_q  (addr_q),
  .pc_q    (pc_q),
  .sp_q    (sp_q),
  .ix_q    (ix_q)
);

// File: tb/test_addr_gen_unit.sv
`timescale 1ns/1ps
module test_addr_gen_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [7:0]  bus_in = 8'h00;
  logic [1:0]  byte_ld = 2'b00;
  logic        ix_load = 1'b0;
  logic [15:0] addr_q, pc_q, sp_q, ix_q;

  int n_checks = 0;
  int n_errors = 0;
  int m_ar, m_pc, m_sp, m_ix, m_tmp;

  always #4 clk = ~clk;

  addr_gen_unit i_addr_gen_unit (
    .clk(clk), .rst_n(rst_n), .go(go), .mode(mode), .bus_in(bus_in),
    .byte_ld(byte_ld), .ix_load(ix_load),
    .addr_q(addr_q), .pc_q(pc_q), .sp_q(sp_q), .ix_q(ix_q)
  );

  function automatic int signed_byte(int b);
    return (b >= 128) ? b - 256 : b;
  endfunction

  function automatic int mod16(int v);
    return ((v % 65536) + 65536) % 65536;
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%04h expected=%04h", req, what, got, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, "addr", int'(addr_q), m_ar);
    chk(req, "pc",   int'(pc_q),   m_pc);
    chk(req, "sp",   int'(sp_q),   m_sp);
    chk(req, "ix",   int'(ix_q),   m_ix);
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
  task automatic cyc(logic g, int md, int b, logic [1:0] bl, logic xl);
    go = g; mode = 3'(md); bus_in = 8'(b); byte_ld = bl; ix_load = xl;
    @(negedge clk);
    go = 1'b0; byte_ld = 2'b00; ix_load = 1'b0;
  endtask

  task automatic load_tmp(int v);
    cyc(1'b0, 3, v % 256, 2'b01, 1'b0);
    cyc(1'b0, 5, v / 256, 2'b10, 1'b0);
    m_tmp = v;
    chk_all("R11");
  endtask

  task automatic op(int md, int b, string req);
    int s;
    cyc(1'b1, md, b, 2'b00, 1'b0);
    case (md)
      0: begin m_ar = m_pc; m_pc = mod16(m_pc + 1); end
      1: begin m_ar = m_tmp; m_pc = m_tmp; end
      2: begin s = mod16(m_pc + signed_byte(b)); m_pc = s; m_ar = s; end
      3: m_ar = m_tmp;
      4: m_ar = mod16(m_pc + signed_byte(b));
      5: begin m_sp = mod16(m_sp - 1); m_ar = m_sp; end
      6: begin m_ar = m_sp; m_sp = mod16(m_sp + 1); end
      default: m_ar = mod16(m_ix + signed_byte(b));
    endcase
    chk_all(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++; n_checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    m_ar = 0; m_pc = 16'h0100; m_sp = 16'hFFFF; m_ix = 0; m_tmp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1");

    // R2 sequential fetch from the reset address
    for (int i = 0; i < 3; i++) op(0, 8'h5A, "R2");

    // R10 byte order; R5 absolute data
    load_tmp(16'h1234);
    op(3, 0, "R10");
    op(3, 0, "R5");
    // only the low lane reloaded: the high lane keeps 12h
    cyc(1'b0, 0, 8'hC7, 2'b01, 1'b0); m_tmp = 16'h12C7;
    op(3, 0, "R10");

    // R2 wrap at the top of the address space
    load_tmp(16'hFFFF);
    op(1, 0, "R3");
    op(0, 0, "R2");

    // R3/R4/R6 sweep over every offset byte
    for (int o = 0; o < 256; o++) begin
      int base;
      base = mod16(o * 523 + 16'hFF00);
      load_tmp(base);
      op(1, 0, "R3");
      op(2, o, "R4");
      op(4, 255 - o, "R6");
      load_tmp(mod16(base ^ 16'hA5C3));
      op(3, 0, "R5");
    end

    // R10 index load, R9 indexed sweep at two bases
    load_tmp(16'hFFF0);
    cyc(1'b0, 7, 0, 2'b00, 1'b1); m_ix = 16'hFFF0;
    chk_all("R10");
    for (int o = 0; o < 256; o++) op(7, o, "R9");
    load_tmp(16'h0005);
    cyc(1'b0, 7, 0, 2'b00, 1'b1); m_ix = 16'h0005;
    chk_all("R10");
    for (int o = 0; o < 256; o++) op(7, o, "R9");

    // R8 pop across the top, R7 push across the bottom, then LIFO order
    op(6, 0, "R8");
    op(5, 0, "R7");
    op(5, 0, "R7");
    op(5, 0, "R7");
    op(5, 0, "R7");
    op(6, 0, "R8");
    op(6, 0, "R8");
    op(6, 0, "R8");
    op(6, 0, "R8");

    // R11 idle cycles with changing mode and bus; R12 pointer isolation is in chk_all
    for (int i = 0; i < 16; i++) begin
      cyc(1'b0, i % 8, i * 37, 2'b00, 1'b0);
      chk_all("R11");
    end
    op(0, 0, "R12");
    op(5, 0, "R12");

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule